// File: doc/BRIEF.md
# Read-Sampling Delay Calibrator

This block tunes the read-capture delay line of a serial flash controller without software help. After a start pulse it decides, from the controller revision and the planned interface clock, whether calibration is worth doing. If it is, it asks for the slow safe clock, reads a three-byte identifier from the flash as a reference, and then returns to the target clock. It steps the delay-cell setting upward and re-reads the identifier at each setting, comparing it against the reference.

The passing settings form a window. If the window is wide enough, the block programs a setting inside it. A window that touches zero but not the top gets a setting biased towards its low side. Otherwise the setting is the window's centre. A failed calibration disables the delay line and raises a request to fall back to the slow clock. Identifier reads go through a simple request/acknowledge handshake to an external command engine. The delay-line register is written through a write strobe and a data bus.

Top module: `sdly_calib`

## Requirements
- R1: On `start`, calibration runs only if `version` >= 4 and `target_mhz` > 50. If `version` >= 4 and `target_mhz` <= 50, the block writes the delay register once with 0, pulses `done`, and issues no probe. If `version` < 4, it pulses `done` with no register write and no probe.
- R2: The cell limit is 511 for version 4 and 255 for version 5. Every other version gives 0.
- R3: The reference read uses command 0x9F on `probe_cmd`. `slow_clk_sel` is high while the reference request is outstanding and low during every sweep probe.
- R4: Byte 0 is `probe_id[7:0]` and byte 1 is `probe_id[15:8]`. If both are 0xFF, or both are 0x00, in the reference read, the device counts as absent. The block then ends with no sweep, no register write, `success`=0, `cells`=0 and no clock-drop request.
- R5: The sweep tests settings 0, 10, 20 and so on. When the next step would exceed the limit, the next setting tested is exactly the limit, and the sweep ends after that test. Before each sweep probe request, the delay register is written with that probe's setting.
- R6: A probe passes when all three bytes equal the reference. The left edge is the first passing setting. The right edge is the last passing setting before the first failure that follows a pass, or before the sweep ends. The first failure after a pass ends the sweep. If nothing passes, both edges read 0.
- R7: Calibration succeeds only if some setting passed and right minus left is at least 80.
- R8: On success, if left = 0 and right is below the limit, the chosen count is left + ((right-left)*2)/5, with truncating division.
- R9: On any other success, the chosen count is left + (right-left)/2, with truncating division.
- R10: On failure after a sweep, `cells` is 0, the delay register is written with 0, and `clk_drop_req` goes high and stays high until the next start.
- R11: A register write carries bit 15 set together with the count clamped to the limit in the low bits. A count of 0 writes the whole 16-bit value as 0.
- R12: `probe_req` stays high with a stable `probe_cells` until `probe_ack`. `done` is a one-cycle pulse. `success`, `cells`, `left_edge`, `right_edge` and `clk_drop_req` hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration decision |
| version | input | 4 | Controller revision |
| target_mhz | input | 10 | Planned interface clock in MHz |
| probe_req | output | 1 | Identifier read request |
| probe_cmd | output | 8 | Command byte for the read |
| probe_cells | output | 9 | Delay setting the probe runs at |
| probe_ack | input | 1 | Read complete, `probe_id` valid |
| probe_id | input | 24 | Three identifier bytes, byte 0 in bits 7:0 |
| slow_clk_sel | output | 1 | Request the safe threshold clock |
| dly_we | output | 1 | Delay register write strobe |
| dly_data | output | 16 | Delay register value |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Calibration found a usable window |
| cells | output | 9 | Chosen delay count |
| left_edge | output | 9 | First passing setting |
| right_edge | output | 9 | Last passing setting |
| clk_drop_req | output | 1 | Request to lower the clock after failure |

## Verification
The bench builds the block with its default parameters: step 10, minimum window 80, threshold 50 MHz and 9-bit cells. This exposes both cell limits, 511 and 255. A flash model passes only inside a chosen window. Windows are placed to produce the 2/5 bias, the midpoint at a window reaching the limit, the irregular final step to 255, and the exact 80-cell boundary. Runs with absent devices, an old revision, a slow clock and a window with no passing setting cover the paths that skip or abandon the sweep.

// File: rtl/sdly_pkg.sv
package sdly_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_SET,
    ST_ISSUE,
    ST_WAIT,
    ST_PICK
  } sdly_state_t;
endpackage

// File: rtl/sdly_limit.sv
module sdly_limit #(
  parameter int VER_W  = 4,
  parameter int CELL_W = 9
) (
  input  logic [VER_W-1:0]  version,
  output logic [CELL_W-1:0] max_cells
);
  localparam logic [CELL_W-1:0] LIM_V4 = CELL_W'(511);
  localparam logic [CELL_W-1:0] LIM_V5 = CELL_W'(255);

  always_comb begin
    if (version == VER_W'(4))      max_cells = LIM_V4;
    else if (version == VER_W'(5)) max_cells = LIM_V5;
    else                           max_cells = '0;
  end
endmodule

// File: rtl/sdly_idcmp.sv
module sdly_idcmp #(
  parameter int NBYTES = 3
) (
  input  logic [8*NBYTES-1:0] ref_id,
  input  logic [8*NBYTES-1:0] rd_id,
  output logic                match,
  output logic                absent
);
  logic [NBYTES-1:0] byte_eq;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_byte
      assign byte_eq[gi] = (ref_id[8*gi +: 8] == rd_id[8*gi +: 8]);
    end
  endgenerate

  assign match  = &byte_eq;
  assign absent = ((rd_id[7:0] == 8'hFF) && (rd_id[15:8] == 8'hFF)) ||
                  ((rd_id[7:0] == 8'h00) && (rd_id[15:8] == 8'h00));
endmodule

// File: rtl/sdly_pick.sv
module sdly_pick #(
  parameter int CELL_W  = 9,
  parameter int MIN_WIN = 80
) (
  input  logic              any_pass,
  input  logic [CELL_W-1:0] left,
  input  logic [CELL_W-1:0] right,
  input  logic [CELL_W-1:0] max_cells,
  output logic              ok,
  output logic [CELL_W-1:0] choice
);
  localparam int WW = CELL_W + 2;
  logic [WW-1:0] width;
  logic [WW-1:0] biased;
  logic [WW-1:0] centred;
  logic          low_bias;

  always_comb begin
    width    = WW'(right) - WW'(left);
    ok       = any_pass && (width >= WW'(MIN_WIN));
    low_bias = (left == '0) && (right < max_cells);
    biased   = WW'(left) + ((width * WW'(2)) / WW'(5));
    centred  = WW'(left) + (width / WW'(2));
    choice   = low_bias ? biased[CELL_W-1:0] : centred[CELL_W-1:0];
  end
endmodule

// File: rtl/sdly_regfmt.sv
module sdly_regfmt #(
  parameter int CELL_W = 9,
  parameter int REG_W  = 16,
  parameter int EN_BIT = 15
) (
  input  logic [CELL_W-1:0] count,
  input  logic [CELL_W-1:0] max_cells,
  output logic [REG_W-1:0]  reg_val
);
  logic [CELL_W-1:0] clamped;

  always_comb begin
    clamped = (count > max_cells) ? max_cells : count;
    reg_val = '0;
    if (clamped != '0) begin
      reg_val[CELL_W-1:0] = clamped;
      reg_val[EN_BIT]     = 1'b1;
    end
  end
endmodule

// File: rtl/sdly_calib.sv
module sdly_calib
  import sdly_pkg::*;
#(
  parameter int VER_W   = 4,
  parameter int FREQ_W  = 10,
  parameter int CELL_W  = 9,
  parameter int NBYTES  = 3,
  parameter int REG_W   = 16,
  parameter int EN_BIT  = 15,
  parameter int STEP    = 10,
  parameter int MIN_WIN = 80,
  parameter int THR_MHZ = 50,
  parameter int MIN_VER = 4,
  parameter logic [7:0] ID_CMD = 8'h9F
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [VER_W-1:0]     version,
  input  logic [FREQ_W-1:0]    target_mhz,
  output logic                 probe_req,
  output logic [7:0]           probe_cmd,
  output logic [CELL_W-1:0]    probe_cells,
  input  logic                 probe_ack,
  input  logic [8*NBYTES-1:0]  probe_id,
  output logic                 slow_clk_sel,
  output logic                 dly_we,
  output logic [REG_W-1:0]     dly_data,
  output logic                 done,
  output logic                 success,
  output logic [CELL_W-1:0]    cells,
  output logic [CELL_W-1:0]    left_edge,
  output logic [CELL_W-1:0]    right_edge,
  output logic                 clk_drop_req
);
  localparam int ID_W = 8 * NBYTES;
  localparam int PW   = CELL_W + 1;

  sdly_state_t       st;
  logic [CELL_W-1:0] lim_now;
  logic [CELL_W-1:0] lim_q;
  logic [ID_W-1:0]   ref_q;
  logic [CELL_W-1:0] point;
  logic              any_pass;
  logic              hit;
  logic              rd_absent;
  logic              pick_ok;
  logic [CELL_W-1:0] pick_val;
  logic [REG_W-1:0]  fmt_point;
  logic [REG_W-1:0]  fmt_pick;
  logic [PW-1:0]     step_sum;
  logic [CELL_W-1:0] next_point;

  sdly_limit #(.VER_W(VER_W), .CELL_W(CELL_W)) u_limit (
    .version   (version),
    .max_cells (lim_now)
  );

  sdly_idcmp #(.NBYTES(NBYTES)) u_cmp (
    .ref_id (ref_q),
    .rd_id  (probe_id),
    .match  (hit),
    .absent (rd_absent)
  );

  sdly_pick #(.CELL_W(CELL_W), .MIN_WIN(MIN_WIN)) u_pick (
    .any_pass  (any_pass),
    .left      (left_edge),
    .right     (right_edge),
    .max_cells (lim_q),
    .ok        (pick_ok),
    .choice    (pick_val)
  );

  sdly_regfmt #(.CELL_W(CELL_W), .REG_W(REG_W), .EN_BIT(EN_BIT)) u_fmt_pt (
    .count     (point),
    .max_cells (lim_q),
    .reg_val   (fmt_point)
  );

  sdly_regfmt #(.CELL_W(CELL_W), .REG_W(REG_W), .EN_BIT(EN_BIT)) u_fmt_pk (
    .count     (pick_ok ? pick_val : '0),
    .max_cells (lim_q),
    .reg_val   (fmt_pick)
  );

  always_comb begin
    step_sum   = PW'(point) + PW'(STEP);
    next_point = (step_sum > PW'(lim_q)) ? lim_q : step_sum[CELL_W-1:0];
  end

  assign probe_cmd   = ID_CMD;
  assign probe_cells = point;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      lim_q        <= '0;
      ref_q        <= '0;
      point        <= '0;
      any_pass     <= 1'b0;
      probe_req    <= 1'b0;
      slow_clk_sel <= 1'b0;
      dly_we       <= 1'b0;
      dly_data     <= '0;
      done         <= 1'b0;
      success      <= 1'b0;
      cells        <= '0;
      left_edge    <= '0;
      right_edge   <= '0;
      clk_drop_req <= 1'b0;
    end else begin
      done   <= 1'b0;
      dly_we <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            lim_q        <= lim_now;
            point        <= '0;
            any_pass     <= 1'b0;
            success      <= 1'b0;
            cells        <= '0;
            left_edge    <= '0;
            right_edge   <= '0;
            clk_drop_req <= 1'b0;
            if (version >= VER_W'(MIN_VER) && target_mhz > FREQ_W'(THR_MHZ)) begin
              slow_clk_sel <= 1'b1;
              probe_req    <= 1'b1;
              st           <= ST_REF;
            end else begin
              if (version >= VER_W'(MIN_VER)) begin
                dly_we   <= 1'b1;
                dly_data <= '0;
              end
              done <= 1'b1;
            end
          end
        end
        ST_REF: begin
          if (probe_ack) begin
            probe_req    <= 1'b0;
            slow_clk_sel <= 1'b0;
            ref_q        <= probe_id;
            if (rd_absent) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              st <= ST_SET;
            end
          end
        end
        ST_SET: begin
          dly_we   <= 1'b1;
          dly_data <= fmt_point;
          st       <= ST_ISSUE;
        end
        ST_ISSUE: begin
          probe_req <= 1'b1;
          st        <= ST_WAIT;
        end
        ST_WAIT: begin
          if (probe_ack) begin
            probe_req <= 1'b0;
            if (any_pass && !hit) begin
              st <= ST_PICK;
            end else begin
              if (hit) begin
                if (!any_pass) left_edge <= point;
                right_edge <= point;
                any_pass   <= 1'b1;
              end
              if (point == lim_q) begin
                st <= ST_PICK;
              end else begin
                point <= next_point;
                st    <= ST_SET;
              end
            end
          end
        end
        ST_PICK: begin
          success      <= pick_ok;
          cells        <= pick_ok ? pick_val : '0;
          dly_we       <= 1'b1;
          dly_data     <= fmt_pick;
          clk_drop_req <= !pick_ok;
          done         <= 1'b1;
          st           <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R12: an outstanding probe keeps its request and setting until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    probe_req && !probe_ack |=> probe_req && $stable(probe_cells));

  // R12: completion is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: written count never exceeds the latched limit
  a_r11_clamp: assert property (@(posedge clk) disable iff (rst)
    dly_we |-> dly_data[CELL_W-1:0] <= lim_q);

  // R11: a disabled write is entirely zero
  a_r11_zero_off: assert property (@(posedge clk) disable iff (rst)
    dly_we && !dly_data[EN_BIT] |-> dly_data == '0);

  // R7: a reported success always spans the minimum window
  a_r7_window: assert property (@(posedge clk) disable iff (rst)
    done && success |-> (PW'(right_edge) - PW'(left_edge)) >= PW'(MIN_WIN));

  // R8 R9: chosen setting lies inside the passing window
  a_r9_inside: assert property (@(posedge clk) disable iff (rst)
    done && success |-> cells >= left_edge && cells <= right_edge);

  // R10: the clock-drop request only appears alongside a failed completion
  a_r10_drop: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_drop_req) |-> done && !success);

  // R3: the slow clock is never held during a sweep register write
  a_r3_slow_ref: assert property (@(posedge clk) disable iff (rst)
    dly_we |-> !slow_clk_sel);
endmodule

// File: tb/sim_sdly_calib.sv
module sim_sdly_calib;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [3:0]  version;
  logic [9:0]  target_mhz;
  logic        probe_req;
  logic [7:0]  probe_cmd;
  logic [8:0]  probe_cells;
  logic        probe_ack;
  logic [23:0] probe_id;
  logic        slow_clk_sel;
  logic        dly_we;
  logic [15:0] dly_data;
  logic        done;
  logic        success;
  logic [8:0]  cells;
  logic [8:0]  left_edge;
  logic [8:0]  right_edge;
  logic        clk_drop_req;

  int checks = 0;
  int fails  = 0;

  // flash model state
  int          win_lo, win_hi;
  logic [23:0] ref_resp;
  logic [23:0] good_id = 24'h1840EF;
  int          ref_cnt, sw_cnt, we_cnt;
  int          seq [0:63];
  logic [15:0] cur_reg, last_we;
  int          bad_ref, bad_sweep, bad_hold;

  always #4 clk = ~clk;

  sdly_calib u0 (
    .clk(clk), .rst(rst), .start(start), .version(version),
    .target_mhz(target_mhz), .probe_req(probe_req), .probe_cmd(probe_cmd),
    .probe_cells(probe_cells), .probe_ack(probe_ack), .probe_id(probe_id),
    .slow_clk_sel(slow_clk_sel), .dly_we(dly_we), .dly_data(dly_data),
    .done(done), .success(success), .cells(cells), .left_edge(left_edge),
    .right_edge(right_edge), .clk_drop_req(clk_drop_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // register write monitor
  initial forever begin
    @(negedge clk);
    if (dly_we) begin
      we_cnt++;
      last_we = dly_data;
      cur_reg = dly_data;
    end
  end

  // flash responder
  initial begin
    probe_ack = 1'b0;
    probe_id  = '0;
    forever begin
      @(negedge clk);
      if (probe_req && !probe_ack) begin
        logic        is_ref;
        int          c;
        logic [8:0]  held;
        is_ref = slow_clk_sel;
        held   = probe_cells;
        c      = cur_reg[15] ? int'(cur_reg[8:0]) : 0;
        if (is_ref) begin
          ref_cnt++;
          if (probe_cmd != 8'h9F) bad_ref++;
        end else begin
          if (sw_cnt < 64) seq[sw_cnt] = c;
          if (c != int'(probe_cells)) bad_sweep++;
          sw_cnt++;
        end
        repeat (2) begin
          @(negedge clk);
          if (!probe_req || probe_cells != held) bad_hold++;
          if (!is_ref && slow_clk_sel) bad_ref++;
        end
        if (is_ref) probe_id = ref_resp;
        else probe_id = (c >= win_lo && c <= win_hi) ? good_id : (good_id ^ 24'h00A500);
        probe_ack = 1'b1;
        @(negedge clk);
        probe_ack = 1'b0;
      end
    end
  end

  task automatic clear_model();
    ref_cnt = 0; sw_cnt = 0; we_cnt = 0;
    bad_ref = 0; bad_sweep = 0; bad_hold = 0;
    ref_resp = good_id;
  endtask

  task automatic run(input logic [3:0] v, input int mhz, output int ok);
    int n;
    version    = v;
    target_mhz = 10'(mhz);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n  = 0;
    ok = 0;
    if (done) ok = 1;
    while (!ok && n < 5000) begin
      @(negedge clk);
      n++;
      if (done) ok = 1;
    end
    chk("R12 done seen", ok, 1);
  endtask

  task automatic t_reset();
    chk("R12 reset done", int'(done), 0);
    chk("R12 reset req", int'(probe_req), 0);
    chk("R10 reset drop", int'(clk_drop_req), 0);
    chk("R11 reset we", int'(dly_we), 0);
    chk("R12 reset success", int'(success), 0);
  endtask

  task automatic t_train(input string nm, input logic [3:0] v, input int lo, input int hi);
    int lim, p, l, r, cnt, exp_cell, ok;
    logic valid, pass, succ;
    int exp_seq [0:63];
    lim = (v == 4) ? 511 : (v == 5) ? 255 : 0;
    p = 0; l = 0; r = 0; cnt = 0; valid = 0;
    forever begin
      exp_seq[cnt] = p;
      cnt++;
      pass = (p >= lo && p <= hi);
      if (valid && !pass) break;
      if (pass) begin
        if (!valid) l = p;
        r = p;
        valid = 1;
      end
      if (p == lim) break;
      p = (p + 10 > lim) ? lim : p + 10;
    end
    succ = valid && (r - l >= 80);
    if (!succ) exp_cell = 0;
    else if (l == 0 && r < lim) exp_cell = l + ((r - l) * 2) / 5;
    else exp_cell = l + (r - l) / 2;

    clear_model();
    win_lo = lo; win_hi = hi;
    run(v, 100, ok);
    $display("scenario %s: left=%0d right=%0d cells=%0d", nm, l, r, exp_cell);
    chk("R3 one ref read", ref_cnt, 1);
    chk("R3 ref cmd and slow clock", bad_ref, 0);
    chk("R5 probe count", sw_cnt, cnt);
    for (int i = 0; i < cnt && i < 64; i++) chk("R5 sweep point", seq[i], exp_seq[i]);
    chk("R5 reg matches probe", bad_sweep, 0);
    chk("R12 request held", bad_hold, 0);
    chk("R6 left edge", int'(left_edge), valid ? l : 0);
    chk("R6 right edge", int'(right_edge), valid ? r : 0);
    chk("R7 success", int'(success), int'(succ));
    chk("R8 R9 chosen cells", int'(cells), exp_cell);
    @(negedge clk);
    chk("R12 done one cycle", int'(done), 0);
    chk("R11 final reg", int'(last_we), exp_cell == 0 ? 0 : (32'h8000 | exp_cell));
    chk("R10 drop request", int'(clk_drop_req), int'(!succ));
    repeat (5) @(negedge clk);
    chk("R12 cells held", int'(cells), exp_cell);
    chk("R12 success held", int'(success), int'(succ));
  endtask

  task automatic t_absent(input logic [23:0] resp);
    int ok;
    clear_model();
    ref_resp = resp;
    run(4'd4, 120, ok);
    chk("R4 no sweep", sw_cnt, 0);
    chk("R4 no reg write", we_cnt, 0);
    chk("R4 success low", int'(success), 0);
    chk("R4 cells zero", int'(cells), 0);
    chk("R4 no drop", int'(clk_drop_req), 0);
  endtask

  task automatic t_slow_clock();
    int ok;
    clear_model();
    run(4'd5, 50, ok);
    @(negedge clk);
    chk("R1 no probe at 50 MHz", ref_cnt + sw_cnt, 0);
    chk("R1 one write", we_cnt, 1);
    chk("R1 write zero", int'(last_we), 0);
  endtask

  task automatic t_old_version();
    int ok;
    clear_model();
    run(4'd3, 150, ok);
    @(negedge clk);
    chk("R1 old version no probe", ref_cnt + sw_cnt, 0);
    chk("R1 old version no write", we_cnt, 0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; version = '0; target_mhz = '0;
    cur_reg = '0; last_we = '0; win_lo = 0; win_hi = 0;
    clear_model();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_train("R9 v4 midpoint", 4'd4, 30, 300);
    t_train("R8 v5 low bias", 4'd5, 0, 150);
    t_train("R2 R5 v5 reaches limit 255", 4'd5, 0, 255);
    t_train("R2 v4 reaches limit 511", 4'd4, 0, 600);
    t_train("R7 exactly 80", 4'd4, 20, 100);
    t_train("R7 R10 narrow fail", 4'd4, 40, 115);
    t_train("R6 R10 nothing passes", 4'd5, 1000, 1000);
    t_absent(24'h12FFFF);
    t_absent(24'h340000);
    t_slow_clock();
    t_old_version();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R12 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule